// File: doc/BRIEF.md
# Keypad Frequency Code Entry with Band Select

This block lets an operator type a four-digit decimal frequency code on a 4x4 key matrix. It drives the matrix one column at a time and reads the rows. It filters key bounce over whole scan sweeps and turns each accepted press into one action. Ten keys write a decimal digit into the position the cursor points at. Four other keys move the cursor to one of the four positions, and the two keys left over do nothing.

The stored code leaves the block in two forms. One is a 16-bit packed BCD word, which sets the divide ratio of a frequency synthesizer. The other is a four-digit seven-segment display, driven one digit at a time, which reads directly as the output frequency in kHz.

The block also compares the thousands digit with a 4-bit threshold set on switches. The result drives the oscillator's range-select line high for low codes and low for high codes.

Top module: `keypad_freq_entry`

## Requirements
- R1: Exactly one column line of `kp_col_n` is low at a time. The low column steps through 0, 1, 2, 3 and holds for SCAN_DIV clocks at each step. Key index = column*4 + row, and a low row line means the key at that column and row is pressed.
- R2: Key indices 0 to 9 write that value into the selected position. `bcd_code[15:12]` holds thousands, `[11:8]` hundreds, `[7:4]` tens and `[3:0]` units. Every digit stays in the range 0 to 9.
- R3: Key indices 10, 11, 12 and 13 select thousands, hundreds, tens and units, in that order. The selection persists and does not advance after a digit write.
- R4: Key indices 14 and 15 change neither the code nor the selected position.
- R5: After reset, `bcd_code` is 0, the thousands position is selected, and `band_high` is 1.
- R6: A key is accepted only after it has been seen as the only pressed key in DEB_SCANS consecutive full sweeps. A shorter press has no effect.
- R7: Each press acts once, however long it is held. After an accepted key, nothing is accepted again until a sweep sees no key pressed. A sweep that sees two or more keys pressed is ignored.
- R8: `band_high` is 1 when `bcd_code[15:12]` is at or below `band_limit`, and 0 otherwise. It follows changes of `band_limit` in the same cycle.
- R9: Exactly one bit of `dig_en_n` is low at a time. Bit 3 enables thousands and bit 0 enables units, and each digit is held for REFRESH_DIV clocks. `seg_n` is active low with segment a on bit 0 through segment g on bit 6, and shows the enabled digit.
- R10: `bcd_code` and `band_high` change together in the clock cycle after a digit write is accepted, and at no other time from key activity.
- R11: Each digit is refreshed every 4*REFRESH_DIV clocks, which is at least 200 times per second. The defaults give 250 Hz at a 50 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kp_row_n | input | 4 | Matrix row lines, low while a key in the driven column is pressed |
| kp_col_n | output | 4 | Matrix column drive, one line low at a time |
| band_limit | input | 4 | Threshold from switches for the thousands digit |
| bcd_code | output | 16 | Four packed BCD digits, thousands in the top nibble |
| band_high | output | 1 | Oscillator range select, high when the thousands digit is at or below the threshold |
| seg_n | output | 7 | Active-low segments a (bit 0) to g (bit 6) |
| dig_en_n | output | 4 | Active-low digit enables, bit 3 for thousands |

## Verification
A key press passes through a two-stage row synchronizer. It then has to survive DEB_SCANS full sweeps, and becomes a code change one cycle after the sweep that accepts it. For this reason the bench never predicts an exact cycle for a key. It holds each key well past the debounce window, and it pushes the expected code and band value into a queue before the press starts. A monitor pops an entry whenever `bcd_code` changes. It also counts a change with nothing queued as a fault, so a press that should have no effect is caught, and after the quiet time each such press gets an explicit check of the code at the ports. `band_high` depends only on `bcd_code` and `band_limit` through logic with no register, so after a change of the threshold it is checked two cycles later. The display is checked against the bench's own digit model only while no key is active, every cycle across two full refresh rounds.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int KEYS   = ROWS * COLS;
  localparam int KW     = $clog2(KEYS);
  localparam int DIGITS = 4;
  localparam int POSW   = $clog2(DIGITS);

  // key classes
  function automatic logic key_writes_digit(input logic [KW-1:0] k);
    return k <= KW'(9);
  endfunction

  function automatic logic key_moves_cursor(input logic [KW-1:0] k);
    return (k >= KW'(10)) && (k <= KW'(13));
  endfunction

  // key 10 -> position 3 (thousands) ... key 13 -> position 0 (units)
  function automatic logic [POSW-1:0] cursor_of(input logic [KW-1:0] k);
    return POSW'(KW'(13) - k);
  endfunction

  function automatic logic [KW-1:0] lowest_set(input logic [KEYS-1:0] m);
    logic [KW-1:0] idx;
    idx = '0;
    for (int i = KEYS - 1; i >= 0; i--) begin
      if (m[i]) idx = KW'(i);
    end
    return idx;
  endfunction

  function automatic logic in_low_band(input logic [3:0] msd, input logic [3:0] limit);
    return msd <= limit;
  endfunction

  // active-high pattern, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [6:0] glyph(input logic [3:0] d);
    logic [6:0] g;
    case (d)
      4'd0: g = 7'h3F;
      4'd1: g = 7'h06;
      4'd2: g = 7'h5B;
      4'd3: g = 7'h4F;
      4'd4: g = 7'h66;
      4'd5: g = 7'h6D;
      4'd6: g = 7'h7D;
      4'd7: g = 7'h07;
      4'd8: g = 7'h7F;
      4'd9: g = 7'h6F;
      default: g = 7'h00;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/kp_scan.sv
module kp_scan
  import kp_pkg::*;
#(
  parameter int SCAN_DIV    = 25000,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_n,
  output logic [COLS-1:0] col_n,
  output logic            sweep_done,
  output logic [KEYS-1:0] sweep_map
);
  localparam int DW = $clog2(SCAN_DIV + 1);
  localparam int CW = $clog2(COLS);

  logic [DW-1:0]   div_cnt;
  logic [CW-1:0]   col_idx;
  logic            step_tick;
  logic [ROWS-1:0] sync_q [SYNC_STAGES];
  logic [ROWS-1:0] rows_hit;
  logic [KEYS-1:0] acc;
  logic [KEYS-1:0] acc_merged;

  assign step_tick = (div_cnt == DW'(SCAN_DIV - 1));
  assign col_n     = ~(COLS'(1) << col_idx);
  assign rows_hit  = ~sync_q[SYNC_STAGES-1];

  // row synchronizer, depth picked by parameter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '1;
    end else begin
      sync_q[0] <= row_n;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  always_comb begin
    acc_merged = acc;
    for (int c = 0; c < COLS; c++) begin
      if (col_idx == CW'(c)) acc_merged[c*ROWS +: ROWS] = acc[c*ROWS +: ROWS] | rows_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt    <= '0;
      col_idx    <= '0;
      acc        <= '0;
      sweep_done <= 1'b0;
      sweep_map  <= '0;
    end else begin
      sweep_done <= 1'b0;
      if (step_tick) begin
        div_cnt <= '0;
        col_idx <= col_idx + CW'(1);
        if (col_idx == CW'(COLS - 1)) begin
          sweep_map  <= acc_merged;
          sweep_done <= 1'b1;
          acc        <= '0;
        end else begin
          acc <= acc_merged;
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(col_n)); // R1
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> !$stable(col_n)); // R1
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce
  import kp_pkg::*;
#(
  parameter int DEB_SCANS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sweep_done,
  input  logic [KEYS-1:0] sweep_map,
  output logic            key_evt,
  output logic [KW-1:0]   key_code
);
  localparam int NW = $clog2(DEB_SCANS + 1);

  logic [NW-1:0] run_cnt, run_nxt;
  logic [KW-1:0] last_key, seen_key;
  logic          have_last, fired;
  logic          one_key, no_key;

  assign one_key  = ($countones(sweep_map) == 1);
  assign no_key   = (sweep_map == '0);
  assign seen_key = lowest_set(sweep_map);

  always_comb begin
    if (have_last && (seen_key == last_key))
      run_nxt = (run_cnt == NW'(DEB_SCANS)) ? run_cnt : run_cnt + NW'(1);
    else
      run_nxt = NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      last_key  <= '0;
      have_last <= 1'b0;
      fired     <= 1'b0;
      key_evt   <= 1'b0;
      key_code  <= '0;
    end else begin
      key_evt <= 1'b0;
      if (sweep_done) begin
        if (no_key) begin
          run_cnt   <= '0;
          have_last <= 1'b0;
          fired     <= 1'b0;
        end else if (one_key) begin
          run_cnt   <= run_nxt;
          last_key  <= seen_key;
          have_last <= 1'b1;
          if ((run_nxt == NW'(DEB_SCANS)) && !fired) begin
            key_evt  <= 1'b1;
            key_code <= seen_key;
            fired    <= 1'b1;
          end
        end else begin
          run_cnt   <= '0;
          have_last <= 1'b0;
        end
      end
    end
  end

  AST_EVT_FROM_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    key_evt |-> $past(sweep_done)); // R6
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_evt |=> !key_evt); // R7
endmodule

// File: rtl/kp_digits.sv
module kp_digits
  import kp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_evt,
  input  logic [KW-1:0]       key_code,
  input  logic [3:0]          band_limit,
  output logic [4*DIGITS-1:0] bcd_code,
  output logic                band_high
);
  logic [3:0]      dig [DIGITS];
  logic [POSW-1:0] cursor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DIGITS; i++) dig[i] <= 4'd0;
      cursor <= POSW'(DIGITS - 1);
    end else if (key_evt) begin
      if (key_writes_digit(key_code)) dig[cursor] <= 4'(key_code);
      else if (key_moves_cursor(key_code)) cursor <= cursor_of(key_code);
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_pack
    assign bcd_code[g*4 +: 4] = dig[g];
  end

  assign band_high = in_low_band(dig[DIGITS-1], band_limit);

  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_code[3:0] <= 4'd9) && (bcd_code[7:4] <= 4'd9) &&
    (bcd_code[11:8] <= 4'd9) && (bcd_code[15:12] <= 4'd9)); // R2
  AST_CODE_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bcd_code) |-> $past(key_evt)); // R10
  AST_IGNORED_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_evt && (key_code > KW'(13))) |=> ($stable(bcd_code) && $stable(cursor))); // R4
endmodule

// File: rtl/kp_display.sv
module kp_display
  import kp_pkg::*;
#(
  parameter int REFRESH_DIV = 50000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4*DIGITS-1:0] bcd_code,
  output logic [6:0]          seg_n,
  output logic [DIGITS-1:0]   dig_en_n
);
  localparam int RW = $clog2(REFRESH_DIV + 1);

  logic [RW-1:0]   ref_cnt;
  logic [POSW-1:0] slot;
  logic            advance;
  logic [3:0]      shown;

  assign advance  = (ref_cnt == RW'(REFRESH_DIV - 1));
  assign dig_en_n = ~(DIGITS'(1) << slot);

  always_comb begin
    shown = 4'd0;
    for (int i = 0; i < DIGITS; i++) begin
      if (slot == POSW'(i)) shown = bcd_code[i*4 +: 4];
    end
  end

  assign seg_n = ~glyph(shown);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      slot    <= POSW'(DIGITS - 1);
    end else if (advance) begin
      ref_cnt <= '0;
      slot    <= slot - POSW'(1);
    end else begin
      ref_cnt <= ref_cnt + RW'(1);
    end
  end

  AST_DIG_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_en_n) == 1); // R9
  AST_DIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(dig_en_n)); // R11
endmodule

// File: rtl/keypad_freq_entry.sv
module keypad_freq_entry
  import kp_pkg::*;
#(
  parameter int SCAN_DIV    = 25000,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_SCANS   = 16,
  parameter int REFRESH_DIV = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  kp_row_n,
  output logic [3:0]  kp_col_n,
  input  logic [3:0]  band_limit,
  output logic [15:0] bcd_code,
  output logic        band_high,
  output logic [6:0]  seg_n,
  output logic [3:0]  dig_en_n
);
  logic            sweep_done;
  logic [KEYS-1:0] sweep_map;
  logic            key_evt;
  logic [KW-1:0]   key_code;

  kp_scan #(.SCAN_DIV(SCAN_DIV), .SYNC_STAGES(SYNC_STAGES)) u_scan (
    .clk(clk), .rst_n(rst_n), .row_n(kp_row_n), .col_n(kp_col_n),
    .sweep_done(sweep_done), .sweep_map(sweep_map));

  kp_debounce #(.DEB_SCANS(DEB_SCANS)) u_deb (
    .clk(clk), .rst_n(rst_n), .sweep_done(sweep_done), .sweep_map(sweep_map),
    .key_evt(key_evt), .key_code(key_code));

  kp_digits u_dig (
    .clk(clk), .rst_n(rst_n), .key_evt(key_evt), .key_code(key_code),
    .band_limit(band_limit), .bcd_code(bcd_code), .band_high(band_high));

  kp_display #(.REFRESH_DIV(REFRESH_DIV)) u_disp (
    .clk(clk), .rst_n(rst_n), .bcd_code(bcd_code), .seg_n(seg_n), .dig_en_n(dig_en_n));
endmodule

// File: tb/tb_keypad_freq_entry.sv
module tb_keypad_freq_entry;
  localparam int SCAN_DIV = 4;
  localparam int DEB      = 16;
  localparam int RDIV     = 8;
  localparam int SWEEP    = 4 * SCAN_DIV;
  localparam longint CLK_HZ = 200_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  row_in;
  logic [3:0]  col_out;
  logic [3:0]  band_limit = 4'd3;
  logic [15:0] bcd_code;
  logic        band_high;
  logic [6:0]  seg_n;
  logic [3:0]  dig_en_n;
  logic [15:0] held = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keypad_freq_entry #(.SCAN_DIV(SCAN_DIV), .DEB_SCANS(DEB), .REFRESH_DIV(RDIV)) dut (
    .clk(clk), .rst_n(rst_n), .kp_row_n(row_in), .kp_col_n(col_out),
    .band_limit(band_limit), .bcd_code(bcd_code), .band_high(band_high),
    .seg_n(seg_n), .dig_en_n(dig_en_n));

  // matrix model: key index = column*4 + row
  always_comb begin
    row_in = 4'hF;
    for (int c = 0; c < 4; c++)
      if (!col_out[c])
        for (int r = 0; r < 4; r++)
          if (held[c*4+r]) row_in[r] = 1'b0;
  end

  typedef struct { logic [15:0] code; logic band; } exp_t;
  exp_t q[$];
  logic [3:0] m_dig [4] = '{4'd0, 4'd0, 4'd0, 4'd0};
  int m_sel = 3;
  logic [15:0] mon_last = '0;

  function automatic logic [15:0] m_code();
    return {m_dig[3], m_dig[2], m_dig[1], m_dig[0]};
  endfunction

  // segments lit, bit0=a .. bit6=g, listed per digit
  function automatic logic [6:0] lit(input logic [3:0] d);
    case (d)
      0: return 7'b0111111; 1: return 7'b0000110; 2: return 7'b1011011;
      3: return 7'b1001111; 4: return 7'b1100110; 5: return 7'b1101101;
      6: return 7'b1111101; 7: return 7'b0000111; 8: return 7'b1111111;
      9: return 7'b1101111; default: return 7'b0000000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_accept(input int key);
    if (key <= 9) begin
      if (m_dig[m_sel] != 4'(key)) begin
        exp_t e;
        m_dig[m_sel] = 4'(key);
        e.code = m_code();
        e.band = (m_dig[3] <= band_limit);
        q.push_back(e);
      end
    end else if (key <= 13) begin
      m_sel = 13 - key;
    end
  endtask

  task automatic wait_sweeps(input int n);
    repeat (n * SWEEP) @(negedge clk);
  endtask

  // driver: expected result queued before the press
  task automatic press(input int key, input int hold);
    if (hold >= DEB + 4) model_accept(key);
    @(negedge clk);
    held = 16'(1) << key;
    wait_sweeps(hold);
    held = '0;
    wait_sweeps(24);
  endtask

  // monitor: scoreboard pop on every code change
  always @(negedge clk) begin
    if (rst_n && !done && (bcd_code !== mon_last)) begin
      if (q.size() == 0) begin
        check(1'b0, "R10", "unexpected code change", bcd_code, mon_last);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(bcd_code == e.code, "R2", "code after write", bcd_code, e.code);
        check(band_high == e.band, "R8", "band with code", band_high, e.band);
      end
      mon_last = bcd_code;
    end
  end

  task automatic display_check();
    int bad = 0;
    int first_bad_seg = 0;
    repeat (8 * RDIV) begin
      @(negedge clk);
      if ($countones(~dig_en_n) != 1) bad++;
      else
        for (int i = 0; i < 4; i++)
          if (!dig_en_n[i] && (seg_n != ~lit(m_dig[i]))) begin
            bad++;
            first_bad_seg = int'(seg_n);
          end
    end
    check(bad == 0, "R9", "display digit/segments mismatches", bad, 0);
    if (bad != 0) $display("  last bad seg_n=%0h", first_bad_seg);
  endtask

  task automatic refresh_check();
    int n = 0;
    @(negedge clk);
    while (dig_en_n[3] != 1'b0) @(negedge clk);
    while (dig_en_n[3] == 1'b0) @(negedge clk);
    while (dig_en_n[3] != 1'b0) begin n++; @(negedge clk); end
    n = n + RDIV;
    check(n == 4 * RDIV, "R11", "refresh period cycles", n, 4 * RDIV);
    check(longint'(n) <= CLK_HZ / 200, "R11", "refresh at least 200 Hz", n, CLK_HZ / 200);
  endtask

  task automatic col_check();
    int bad = 0;
    logic [3:0] prev;
    int run = 0;
    int steps = 0;
    @(negedge clk);
    prev = col_out;
    repeat (8 * SWEEP) begin
      @(negedge clk);
      if ($countones(~col_out) != 1) bad++;
      if (col_out == prev) run++;
      else begin
        if (steps > 0 && run != SCAN_DIV - 1) bad++;
        if (col_out != {prev[2:0], prev[3]}) bad++;
        steps++;
        run = 0;
      end
      prev = col_out;
    end
    check(bad == 0, "R1", "column drive pattern faults", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check(bcd_code == 16'h0000, "R5", "code after reset", bcd_code, 0);
    check(band_high == 1'b1, "R5", "band after reset", band_high, 1);
    col_check();
    display_check();

    press(1, 20);                       // R5: thousands selected by reset
    press(13, 20); press(7, 20);        // R3: units
    press(11, 20); press(9, 20);        // R3: hundreds
    press(12, 20); press(5, 20);        // R3: tens
    check(bcd_code == 16'h1957, "R3", "code after cursor writes", bcd_code, 16'h1957);

    press(2, 8);                        // R6: too short
    check(bcd_code == 16'h1957, "R6", "short press ignored", bcd_code, 16'h1957);

    press(14, 20); press(15, 20);       // R4
    check(bcd_code == 16'h1957, "R4", "keys 14/15 leave code", bcd_code, 16'h1957);
    press(6, 20);                       // R4: cursor still on tens
    check(bcd_code == 16'h1967, "R4", "cursor kept after 14/15", bcd_code, 16'h1967);

    // R7: held key acts once; chord then lone key without release is not accepted
    model_accept(3);
    @(negedge clk); held = 16'(1) << 3;
    wait_sweeps(20);
    held = (16'(1) << 3) | (16'(1) << 8);
    wait_sweeps(20);
    held = 16'(1) << 8;
    wait_sweeps(30);
    held = '0;
    wait_sweeps(24);
    check(bcd_code == 16'h1937, "R7", "no re-accept without release", bcd_code, 16'h1937);
    press(8, 20);
    check(bcd_code == 16'h1987, "R7", "accepted after release", bcd_code, 16'h1987);

    // R8 band compare
    press(10, 20); press(3, 20);
    check(band_high == 1'b1, "R8", "digit 3 limit 3", band_high, 1);
    press(4, 20);
    check(band_high == 1'b0, "R8", "digit 4 limit 3", band_high, 0);
    @(negedge clk); band_limit = 4'd4; repeat (2) @(negedge clk);
    check(band_high == 1'b1, "R8", "digit 4 limit 4", band_high, 1);
    band_limit = 4'd0; repeat (2) @(negedge clk);
    check(band_high == 1'b0, "R8", "digit 4 limit 0", band_high, 0);
    band_limit = 4'd15; repeat (2) @(negedge clk);
    check(band_high == 1'b1, "R8", "digit 4 limit 15", band_high, 1);
    band_limit = 4'd3; repeat (2) @(negedge clk);
    press(9, 20);
    check(band_high == 1'b0, "R8", "digit 9 limit 3", band_high, 0);

    display_check();
    refresh_check();
    check(q.size() == 0, "R10", "scoreboard drained", q.size(), 0);
    check(bcd_code == m_code(), "R2", "final code", bcd_code, m_code());

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule